// File: doc/BRIEF.md
# Channel-Status and User-Bit Block Collector

This block sits behind a digital-audio line decoder. For every decoded subframe it takes the channel-status bit, the user bit, the channel index and a flag that marks the block-opening preamble. It assembles those bits into one 192-bit status set and one 192-bit user set per channel, for two channels. A block is 192 frames, and each frame carries one subframe per channel.

Bits first collect in a shadow store. They move into the readable store in a single cycle, and only when a block has fully arrived. A register read port therefore always returns data from one whole block. When a block completes, the block raises a block-end event, and it raises a per-channel status-change event whenever that channel's 192 status bits differ from the previous latched block. Each accepted block opening raises a block-start event. All events are single-cycle pulses on an interrupt-vector output.

Subframes enter on a valid/ready stream. The block never applies back-pressure: ready is always high, and a subframe counts as transferred in every cycle where valid is high.

Top module: `cub_capture`

## Requirements
- R1: After reset every readable word returns 0 and no event bit pulses.
- R2: For each channel and kind, the bit carried by frame k (k = 0 for the opening frame) is readable at word k/32, bit k%32 of that set. Channel 0 status starts at byte address 0x30, channel 0 user data at 0x48, channel 1 status at 0x60 and channel 1 user data at 0x78. Each set has six words at a stride of 4.
- R3: A block opens only on a transferred channel-0 subframe that has the start flag set. A start flag on a channel-1 subframe is ignored. Subframes that arrive while no block is open leave the readable words unchanged.
- R4: The readable words change only in the cycle after the channel-1 subframe of frame 191 transfers. Partly received blocks are never visible.
- R5: Block end pulses event bit 3 for exactly one cycle, in the cycle after the completing subframe transfers.
- R6: Every accepted block opening pulses event bit 11 for one cycle, in the cycle after that subframe transfers.
- R7: At block end, event bit 8+n pulses together with bit 3 when the 192 status bits of channel n differ from the previously latched status, and always for the first completed block after reset. Differences in user data do not raise this event.
- R8: A new opening that arrives while a block is still open discards the partial block. No block-end event is raised for it, the readable words keep their previous content, and capture restarts at frame 0.
- R9: A read presents its word on the data output in the cycle after the read strobe. Addresses that are misaligned or outside 0x30..0x8F return 0. The data output holds its value while no read is strobed.
- R10: The input ready signal is high in every cycle after reset, so no subframe is ever stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Subframe present on the stream inputs |
| in_ready | output | 1 | Always high; the block never stalls the stream |
| in_chan | input | 1 | Channel index of the subframe |
| in_cbit | input | 1 | Channel-status bit of the subframe |
| in_ubit | input | 1 | User bit of the subframe |
| in_bstart | input | 1 | Subframe follows the block-opening preamble |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Byte address of the word to read |
| rd_data | output | 32 | Read data, valid the cycle after the strobe |
| evt_vec | output | 15 | Event pulses: bit 3 block end, bits 8/9 status change, bit 11 block start |

## Verification
A frame-position counter that slips or a shadow bit written to the wrong slot shows up as a rotated or misplaced bit in a readable word. It also moves the block-end pulse away from the 384th transferred subframe, so the fault is visible at the first completed block. A comparison register that goes stale produces missing or spurious status-change pulses on the next block that repeats or alters its status. A commit that fires early either exposes partial data to a mid-block read or lets an aborted block leak through, and both cases are visible in the same cycle as the read.

// File: rtl/cub_pkg.sv
package cub_pkg;
  localparam int FRAMES    = 192;
  localparam int NCH       = 2;
  localparam int WORD_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int BASE_ADDR = 'h30;
  localparam int EVW       = 15;
  localparam int EV_END    = 3;
  localparam int EV_CSC0   = 8;
  localparam int EV_START  = 11;
  localparam int NSET      = 2 * NCH;
  localparam int WORDS     = FRAMES / WORD_W;
  localparam int SET_BYTES = WORDS * (WORD_W / 8);
  localparam int PW        = $clog2(FRAMES);
endpackage

// File: rtl/cub_seq.sv
module cub_seq #(
  parameter int FRAMES = 192,
  parameter int PW     = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_chan,
  input  logic          in_bstart,
  output logic          wr_en,
  output logic [PW-1:0] wr_pos,
  output logic          commit,
  output logic          start_pls
);
  logic          active;
  logic [PW-1:0] pos;

  assign start_pls = in_valid && in_bstart && !in_chan;
  assign wr_en     = in_valid && (start_pls || active);
  assign wr_pos    = start_pls ? '0 : pos;
  assign commit    = wr_en && in_chan && (wr_pos == PW'(FRAMES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pos    <= '0;
    end else if (start_pls) begin
      active <= 1'b1;
      pos    <= '0;
    end else if (in_valid && active && in_chan) begin
      if (pos == PW'(FRAMES - 1)) begin
        active <= 1'b0;
        pos    <= '0;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos < PW'(FRAMES)) else $error("frame position out of range"); // R2
  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    start_pls |=> active) else $error("opening did not open a block"); // R3
  AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (!active && pos == '0)) else $error("block not closed"); // R4
endmodule

// File: rtl/cub_bitstore.sv
module cub_bitstore #(
  parameter int NBITS = 192,
  parameter int PW    = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PW-1:0]    wr_pos,
  input  logic             wr_bit,
  input  logic             commit,
  output logic [NBITS-1:0] fresh,
  output logic [NBITS-1:0] shown
);
  logic [NBITS-1:0] shadow;

  // shadow with the bit of this cycle merged, so a commit sees the final bit
  always_comb begin
    fresh = shadow;
    if (wr_en) fresh[wr_pos] = wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      shown  <= '0;
    end else begin
      if (wr_en)  shadow[wr_pos] <= wr_bit;
      if (commit) shown <= fresh;
    end
  end

  AST_SHOWN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(shown)) else $error("visible set moved mid-block"); // R4
endmodule

// File: rtl/cub_capture.sv
module cub_capture
  import cub_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_chan,
  input  logic              in_cbit,
  input  logic              in_ubit,
  input  logic              in_bstart,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic [EVW-1:0]    evt_vec
);
  localparam int SSW = $clog2(NSET);
  localparam int WSW = $clog2(WORDS);
  localparam int BW  = $clog2(WORD_W);

  logic          seq_wr, commit, start_pls;
  logic [PW-1:0] wr_pos;
  logic [FRAMES-1:0] fresh [NSET];
  logic [FRAMES-1:0] shown [NSET];
  logic [NCH-1:0] seen, diff;

  assign in_ready = 1'b1;

  cub_seq #(.FRAMES(FRAMES), .PW(PW)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
    .in_bstart(in_bstart), .wr_en(seq_wr), .wr_pos(wr_pos),
    .commit(commit), .start_pls(start_pls)
  );

  // set g: channel g/2, kind g%2 (0 status, 1 user), matching address order
  for (genvar g = 0; g < NSET; g++) begin : g_store
    localparam int CH = g / 2;
    localparam bit IS_USER = (g % 2) == 1;
    cub_bitstore #(.NBITS(FRAMES), .PW(PW)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(seq_wr && (in_chan == 1'(CH))),
      .wr_pos(wr_pos),
      .wr_bit(IS_USER ? in_ubit : in_cbit),
      .commit(commit),
      .fresh(fresh[g]),
      .shown(shown[g])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chg
    assign diff[c] = !seen[c] || (fresh[2*c] != shown[2*c]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen    <= '0;
      evt_vec <= '0;
    end else begin
      evt_vec           <= '0;
      evt_vec[EV_END]   <= commit;
      evt_vec[EV_START] <= start_pls;
      for (int c = 0; c < NCH; c++) evt_vec[EV_CSC0 + c] <= commit && diff[c];
      if (commit) seen <= '1;
    end
  end

  // read decode
  logic           in_rng;
  logic [SSW-1:0] set_sel;
  logic [WSW-1:0] word_sel;
  always_comb begin
    int a, off;
    a        = int'(rd_addr);
    off      = a - BASE_ADDR;
    in_rng   = (a >= BASE_ADDR) && (off < NSET * SET_BYTES) && (rd_addr[1:0] == 2'b00);
    set_sel  = in_rng ? SSW'(off / SET_BYTES) : '0;
    word_sel = in_rng ? WSW'((off % SET_BYTES) / 4) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) rd_data <= in_rng ? shown[set_sel][{word_sel, BW'(0)} +: WORD_W] : '0;
  end

  AST_CSC_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_vec[EV_CSC0 +: NCH]) |-> evt_vec[EV_END]) else $error("status change without block end"); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)) else $error("read data moved without strobe"); // R9
  AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vec[EV_END] |=> !evt_vec[EV_END]) else $error("block end longer than a cycle"); // R5
endmodule

// File: tb/cub_capture_tb.sv
module cub_capture_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FR = 192;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_chan = 1'b0, in_cbit = 1'b0, in_ubit = 1'b0, in_bstart = 1'b0;
  logic in_ready;
  logic rd_en = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [14:0] evt_vec;

  int n_chk = 0, n_fail = 0;
  int n_end = 0, n_start = 0, n_csc0 = 0, n_csc1 = 0;
  logic [FR-1:0] gen [4];
  logic [FR-1:0] exp_s [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  cub_capture u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_chan(in_chan), .in_cbit(in_cbit), .in_ubit(in_ubit), .in_bstart(in_bstart),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .evt_vec(evt_vec)
  );

  always @(negedge clk) begin
    if (evt_vec[3])  n_end++;
    if (evt_vec[11]) n_start++;
    if (evt_vec[8])  n_csc0++;
    if (evt_vec[9])  n_csc1++;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] addr_of(input int set, input int word);
    return 8'('h30 + set * 24 + word * 4);
  endfunction

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 6; w++) begin
        rd(addr_of(s, w), d);
        chk(d == exp_s[s][32*w +: 32], tag, d, exp_s[s][32*w +: 32]);
      end
  endtask

  task automatic send(input bit ch, input bit c, input bit u, input bit bs);
    if ($urandom % 4 == 0) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b1; in_chan = ch; in_cbit = c; in_ubit = u; in_bstart = bs;
    @(posedge clk); #1;
    in_valid = 1'b0; in_bstart = 1'b0;
  endtask

  // sends frames [0, nfr) of gen; commits model when the block is complete
  task automatic send_block(input int nfr);
    for (int f = 0; f < nfr; f++)
      for (int ch = 0; ch < 2; ch++) begin
        send(ch[0], gen[2*ch][f], gen[2*ch+1][f], (f == 0 && ch == 0));
        if (f == FR - 1 && ch == 1) begin
          chk(evt_vec[3] == 1'b1, "R5 end pulse timing", evt_vec[3], 1);
        end else if (f == 0 && ch == 0) begin
          chk(evt_vec[11] == 1'b1, "R6 start pulse timing", evt_vec[11], 1);
        end
      end
    if (nfr == FR) for (int s = 0; s < 4; s++) exp_s[s] = gen[s];
  endtask

  function automatic logic [FR-1:0] rnd192();
    logic [FR-1:0] v;
    for (int i = 0; i < 6; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] d, hold;
    int e0, s0, c0, c1;
    void'($urandom(32'h5EED_1234));
    for (int s = 0; s < 4; s++) exp_s[s] = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R10 ready
    check_all("R1 reset word");
    chk(evt_vec == '0, "R1 no events", evt_vec, 0);
    chk(in_ready == 1'b1, "R10 ready high", in_ready, 1);

    // R3: subframes without an opening are ignored
    for (int f = 0; f < 10; f++) begin
      send(1'b0, 1'b1, 1'b1, 1'b0);
      send(1'b1, 1'b1, 1'b1, 1'b0);
    end
    check_all("R3 no open block");
    chk(n_start == 0, "R3 no start", n_start, 0);

    // R2/R7: first full random block
    for (int s = 0; s < 4; s++) gen[s] = rnd192();
    send_block(FR);
    @(negedge clk);
    check_all("R2 block A word");
    chk(n_end == 1, "R5 end count", n_end, 1);
    chk(n_csc0 == 1 && n_csc1 == 1, "R7 first block change", {n_csc0, n_csc1}, {32'd1, 32'd1});

    // R4: mid-block read shows old data; then finish with same status, new user
    gen[1] = rnd192(); gen[3] = rnd192();
    for (int f = 0; f < 100; f++)
      for (int ch = 0; ch < 2; ch++)
        send(ch[0], gen[2*ch][f], gen[2*ch+1][f], (f == 0 && ch == 0));
    rd(addr_of(1, 0), d);
    chk(d == exp_s[1][31:0], "R4 partial hidden", d, exp_s[1][31:0]);
    for (int f = 100; f < FR; f++)
      for (int ch = 0; ch < 2; ch++)
        send(ch[0], gen[2*ch][f], gen[2*ch+1][f], 1'b0);
    for (int s = 0; s < 4; s++) exp_s[s] = gen[s];
    @(negedge clk);
    check_all("R4 block B word");
    chk(n_csc0 == 1 && n_csc1 == 1, "R7 user change only", {n_csc0, n_csc1}, {32'd1, 32'd1});
    chk(n_end == 2, "R5 end count B", n_end, 2);

    // R8: aborted block, then full block with channel-0 status changed
    e0 = n_end; s0 = n_start;
    for (int s = 0; s < 4; s++) gen[s] = rnd192();
    send_block(77);
    check_all("R8 abort hidden");
    chk(n_end == e0, "R8 no end on abort", n_end, e0);
    gen[2] = exp_s[2];
    send_block(FR);
    @(negedge clk);
    check_all("R8 block D word");
    chk(n_end == e0 + 1, "R8 single end", n_end, e0 + 1);
    chk(n_start == s0 + 2, "R6 two openings", n_start, s0 + 2);
    chk(n_csc0 == 2 && n_csc1 == 1, "R7 ch0 only change", {n_csc0, n_csc1}, {32'd2, 32'd1});

    // R3: start flag on channel 1 ignored; stray subframes ignored
    s0 = n_start;
    for (int f = 0; f < 20; f++) begin
      send(1'b1, 1'b1, 1'b0, 1'b1);
      send(1'b0, 1'b0, 1'b1, 1'b0);
    end
    @(negedge clk);
    chk(n_start == s0, "R3 ch1 flag ignored", n_start, s0);
    check_all("R3 stray ignored");

    // R2 directed: single bit at frame 0 and frame 191
    for (int s = 0; s < 4; s++) gen[s] = '0;
    gen[0][0] = 1'b1; gen[3][FR-1] = 1'b1; gen[2] = exp_s[2];
    c0 = n_csc0; c1 = n_csc1;
    send_block(FR);
    @(negedge clk);
    rd(addr_of(0, 0), d);
    chk(d == 32'h1, "R2 first bit at bit 0", d, 32'h1);
    rd(addr_of(3, 5), d);
    chk(d == 32'h8000_0000, "R2 last bit at word5 bit31", d, 32'h8000_0000);
    chk(n_csc0 == c0 + 1 && n_csc1 == c1, "R7 directed change", {n_csc0, n_csc1}, {c0 + 1, c1});

    // R9: out-of-range and misaligned, hold without strobe
    rd(8'h31, d); chk(d == 0, "R9 misaligned", d, 0);
    rd(8'h2C, d); chk(d == 0, "R9 below range", d, 0);
    rd(8'h90, d); chk(d == 0, "R9 above range", d, 0);
    rd(addr_of(0, 0), hold);
    rd_addr = 8'h60;
    repeat (3) @(negedge clk);
    chk(rd_data == hold, "R9 hold without strobe", rd_data, hold);
    chk(in_ready == 1'b1, "R10 ready high at end", in_ready, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule